// File: doc/BRIEF.md
# Host Bus-Signalling Control Register

This block is the control register through which host software asks for events on the USB bus: a bus reset, a resume, a link-power-management (L1) resume and continuous start-of-frame (SOF) generation. It also holds plain settings that go straight out to the line logic: a VBUS-good flag, the J and K test-state drivers, an auto-resume enable and a two-bit speed selector. Software writes and reads the register at byte offset 0x008 through a simple single-cycle port. The bus-signalling engine reports completion back through single-cycle pulses, and the register updates itself in response.

The request bits are write-one-to-start and clear themselves when the engine reports completion. Writing 0 to them does nothing. A pending bus reset cancels any resume or L1 resume. SOF generation turns on by itself when a reset, a downstream resume or an L1 resume finishes. The length of an L1 resume comes from an internal timer. It counts (BESL+1)×64 clock cycles, and BESL is captured at the moment the request is accepted. If a hardware event and a software write hit the same bit in the same cycle, the hardware event wins.

Top module: `host_sig_ctrl`

## Requirements
- R1: After reset the register reads 0x0000 and every request, enable and run output is low.
- R2: The register reads back in this layout: L1 resume at bit 11, VBUS good at 10, bus reset at 9, SOF enable at 8, test K at 6, test J at 5, auto-resume at 4, speed at 3:2 and resume at 1. Bits 15:12, 7 and 0 always read 0. A read at any address other than 0x008 returns 0, and a write to any other address changes nothing.
- R3: Writing 1 to bit 1 raises `resumeReq` after the write edge. Writing 0 to bit 1 leaves it unchanged. The edge that samples `resumeDone` clears it.
- R4: Writing 1 to bit 9 raises `busResetReq`. Writing 0 to bit 9 leaves it unchanged. The edge that samples `resetDone` or `disconnect` clears it.
- R5: A bus reset request clears the resume and L1 resume bits. This happens while bit 9 is set, and also in the same edge in which a write sets bit 9.
- R6: The edge that samples `resetDone`, `dnResumeDone` or the end of an L1 resume sets `sofEn`. This set wins over a software write of 0 to bit 8 in that same edge.
- R7: A write of 1 to bit 11 is accepted only if `sofEn` was 1 before that write. Otherwise bit 11 stays 0.
- R8: An accepted L1 resume keeps `l1ResumeReq` high for exactly (BESL+1)×64 cycles, using the BESL value present at the accepting write. On the edge that ends it, bit 11 clears and `sofEn` sets.
- R9: `hostRun` is high exactly when VBUS good, `hostConfigured` and `hostEnabled` are all 1.
- R10: `forceFullSpeed` is high only when the speed field holds 3. The values 0, 1 and 2 all mean normal start-up.
- R11: `testJOut` follows bit 5. `testKOut` follows bit 6 only while bit 5 is 0.
- R12: When a completion event and a write of 1 to the same request bit arrive in the same cycle, the completion wins and the bit stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| addr | input | 8 | Byte address for reads and writes |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data (combinational from addr) |
| besl | input | 4 | L1 resume length selector |
| hostConfigured | input | 1 | Host controller is configured |
| hostEnabled | input | 1 | Host controller is enabled |
| resetDone | input | 1 | Pulse: bus reset finished |
| resumeDone | input | 1 | Pulse: resume finished |
| disconnect | input | 1 | Pulse: device disconnect seen |
| dnResumeDone | input | 1 | Pulse: downstream resume finished |
| busResetReq | output | 1 | Bus reset requested |
| resumeReq | output | 1 | Resume requested |
| l1ResumeReq | output | 1 | L1 resume in progress |
| sofEn | output | 1 | SOF generation enabled |
| testJOut | output | 1 | Drive J test state |
| testKOut | output | 1 | Drive K test state |
| autoResumeEn | output | 1 | Auto-resume enabled |
| forceFullSpeed | output | 1 | Host stays at full speed |
| hostRun | output | 1 | Host operation allowed |

## Verification
Every register bit and every output that comes from a register changes on the clock edge that samples the write or the event pulse. That makes it visible one cycle after the stimulus is applied. `rdData`, `hostRun` and `testKOut` are combinational, but they follow the stored bits, so they are due in that same cycle. The L1 resume is due to end exactly (BESL+1)×64 edges after its accepting write, and the bench places one check on the last high cycle and one on the first low cycle. The bench applies stimulus on the falling edge. Each expectation is queued just after the rising edge that should produce it, and the monitor compares it two time units after that rising edge, so each check lands in exactly the cycle its result is due.

// File: rtl/hbc_pkg.sv
package hbc_pkg;
  localparam int REG_W = 16;

  // bit positions that software relies on
  localparam int BIT_L1   = 11;
  localparam int BIT_VBUS = 10;
  localparam int BIT_RST  = 9;
  localparam int BIT_SOF  = 8;
  localparam int BIT_TK   = 6;
  localparam int BIT_TJ   = 5;
  localparam int BIT_AR   = 4;
  localparam int BIT_SPD  = 2;
  localparam int BIT_RES  = 1;

  // plain read/write fields stored straight from the write data
  localparam logic [REG_W-1:0] PLAIN_MASK =
      (REG_W'(1) << BIT_VBUS) | (REG_W'(1) << BIT_TK) | (REG_W'(1) << BIT_TJ) |
      (REG_W'(1) << BIT_AR) | (REG_W'(3) << BIT_SPD);

  typedef enum logic [1:0] {
    SPD_NORMAL = 2'd0,
    SPD_RSVD_A = 2'd1,
    SPD_RSVD_B = 2'd2,
    SPD_FULL   = 2'd3
  } speed_e;

  // strobes from control to register datapath
  typedef struct packed {
    logic setRst;
    logic clrRst;
    logic setRes;
    logic clrRes;
    logic setL1;
    logic clrL1;
    logic setSof;
    logic wrFields;
  } strobe_t;
endpackage

// File: rtl/hbc_l1_timer.sv
module hbc_l1_timer #(
  parameter int BESL_W = 4,
  parameter int UNIT   = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              active,
  input  logic [BESL_W-1:0] besl,
  output logic              done
);
  localparam int MAX_CYC = (2 ** BESL_W) * UNIT;
  localparam int CNT_W   = $clog2(MAX_CYC);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lastCnt;

  assign done = active && (cnt == lastCnt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      lastCnt <= '0;
    end else begin
      if (start) lastCnt <= CNT_W'((int'(besl) + 1) * UNIT - 1);
      if (!active)   cnt <= '0;
      else if (!done) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/hbc_ctrl.sv
module hbc_ctrl
  import hbc_pkg::*;
(
  input  logic    wrHit,
  input  logic    wrRstBit,
  input  logic    wrResBit,
  input  logic    wrL1Bit,
  input  logic    curRst,
  input  logic    curSof,
  input  logic    resetDone,
  input  logic    resumeDone,
  input  logic    disconnect,
  input  logic    dnResumeDone,
  input  logic    l1Done,
  output strobe_t stb
);
  logic rstPending;

  // a reset already held, or one being requested in this cycle
  assign rstPending = curRst || (wrHit && wrRstBit);

  always_comb begin
    stb          = '0;
    stb.wrFields = wrHit;
    stb.setRst   = wrHit && wrRstBit;
    stb.clrRst   = resetDone || disconnect;
    stb.setRes   = wrHit && wrResBit;
    stb.clrRes   = resumeDone || rstPending;
    stb.setL1    = wrHit && wrL1Bit && curSof;
    stb.clrL1    = l1Done || rstPending;
    stb.setSof   = resetDone || dnResumeDone || l1Done;
  end
endmodule

// File: rtl/hbc_regs.sv
module hbc_regs
  import hbc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] regVal,
  output logic             rstQ,
  output logic             resQ,
  output logic             l1Q,
  output logic             sofQ
);
  logic [REG_W-1:0] plainQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      plainQ <= '0;
      rstQ   <= 1'b0;
      resQ   <= 1'b0;
      l1Q    <= 1'b0;
      sofQ   <= 1'b0;
    end else begin
      if (stb.wrFields) plainQ <= wrData & PLAIN_MASK;

      if (stb.clrRst)      rstQ <= 1'b0;
      else if (stb.setRst) rstQ <= 1'b1;

      if (stb.clrRes)      resQ <= 1'b0;
      else if (stb.setRes) resQ <= 1'b1;

      if (stb.clrL1)       l1Q <= 1'b0;
      else if (stb.setL1)  l1Q <= 1'b1;

      if (stb.setSof)        sofQ <= 1'b1;
      else if (stb.wrFields) sofQ <= wrData[BIT_SOF];
    end
  end

  always_comb begin
    regVal          = plainQ;
    regVal[BIT_L1]  = l1Q;
    regVal[BIT_RST] = rstQ;
    regVal[BIT_SOF] = sofQ;
    regVal[BIT_RES] = resQ;
  end
endmodule

// File: rtl/host_sig_ctrl.sv
module host_sig_ctrl
  import hbc_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = ADDR_W'(8'h08),
  parameter int                BESL_W     = 4,
  parameter int                L1_UNIT    = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  input  logic [BESL_W-1:0] besl,
  input  logic              hostConfigured,
  input  logic              hostEnabled,
  input  logic              resetDone,
  input  logic              resumeDone,
  input  logic              disconnect,
  input  logic              dnResumeDone,
  output logic              busResetReq,
  output logic              resumeReq,
  output logic              l1ResumeReq,
  output logic              sofEn,
  output logic              testJOut,
  output logic              testKOut,
  output logic              autoResumeEn,
  output logic              forceFullSpeed,
  output logic              hostRun
);
  logic             addrHit;
  logic             wrHit;
  logic             l1Done;
  logic             rstQ, resQ, l1Q, sofQ;
  logic [REG_W-1:0] regVal;
  strobe_t          stb;
  speed_e           speed;

  assign addrHit = (addr == REG_OFFSET);
  assign wrHit   = wrEn && addrHit;

  hbc_ctrl u_ctrl (
    .wrHit       (wrHit),
    .wrRstBit    (wrData[BIT_RST]),
    .wrResBit    (wrData[BIT_RES]),
    .wrL1Bit     (wrData[BIT_L1]),
    .curRst      (rstQ),
    .curSof      (sofQ),
    .resetDone   (resetDone),
    .resumeDone  (resumeDone),
    .disconnect  (disconnect),
    .dnResumeDone(dnResumeDone),
    .l1Done      (l1Done),
    .stb         (stb)
  );

  hbc_regs u_regs (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .wrData(wrData),
    .regVal(regVal),
    .rstQ  (rstQ),
    .resQ  (resQ),
    .l1Q   (l1Q),
    .sofQ  (sofQ)
  );

  hbc_l1_timer #(.BESL_W(BESL_W), .UNIT(L1_UNIT)) u_timer (
    .clk   (clk),
    .rstN  (rstN),
    .start (stb.setL1 && !stb.clrL1 && !l1Q),
    .active(l1Q),
    .besl  (besl),
    .done  (l1Done)
  );

  assign speed          = speed_e'(regVal[BIT_SPD +: 2]);
  assign rdData         = addrHit ? regVal : '0;
  assign busResetReq    = rstQ;
  assign resumeReq      = resQ;
  assign l1ResumeReq    = l1Q;
  assign sofEn          = sofQ;
  assign testJOut       = regVal[BIT_TJ];
  assign testKOut       = regVal[BIT_TK] && !regVal[BIT_TJ];
  assign autoResumeEn   = regVal[BIT_AR];
  assign forceFullSpeed = (speed == SPD_FULL);
  assign hostRun        = regVal[BIT_VBUS] && hostConfigured && hostEnabled;
endmodule

// File: rtl/hbc_checker.sv
module hbc_checker #(
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = ADDR_W'(8'h08)
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [15:0]       wrData,
  input logic [15:0]       rdData,
  input logic              hostConfigured,
  input logic              hostEnabled,
  input logic              resetDone,
  input logic              resumeDone,
  input logic              disconnect,
  input logic              dnResumeDone,
  input logic              busResetReq,
  input logic              resumeReq,
  input logic              l1ResumeReq,
  input logic              sofEn,
  input logic              testJOut,
  input logic              testKOut,
  input logic              hostRun
);
  assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[15:12] == 4'd0) && !rdData[7] && !rdData[0]);

  assert_resume_done_R3: assert property (@(posedge clk) disable iff (!rstN)
    resumeDone |=> !resumeReq);

  assert_reset_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    (resetDone || disconnect) |=> !busResetReq);

  assert_reset_cancels_R5: assert property (@(posedge clk) disable iff (!rstN)
    busResetReq |=> (!resumeReq && !l1ResumeReq));

  assert_sof_autoset_R6: assert property (@(posedge clk) disable iff (!rstN)
    (resetDone || dnResumeDone) |=> sofEn);

  assert_l1_needs_sof_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(l1ResumeReq) |-> $past(sofEn));

  assert_l1_end_sof_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(l1ResumeReq) && !busResetReq && !$past(busResetReq)) |-> sofEn);

  assert_run_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    hostRun |-> (hostConfigured && hostEnabled));

  assert_test_excl_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(testJOut && testKOut));

  assert_hw_wins_R12: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (addr == REG_OFFSET) && wrData[9] && resetDone) |=> !busResetReq);
endmodule

bind host_sig_ctrl hbc_checker #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_hbc_checker (.*);

// File: tb/test_host_sig_ctrl.sv
module test_host_sig_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] REG = 8'h08;
  localparam logic [3:0] EV_RST = 4'b0001, EV_RES = 4'b0010,
                         EV_DISC = 4'b0100, EV_DNR = 4'b1000;
  // output bundle bit weights
  localparam logic [8:0] O_RST = 9'd1, O_RES = 9'd2, O_L1 = 9'd4, O_SOF = 9'd8,
                         O_TJ = 9'd16, O_TK = 9'd32, O_AR = 9'd64, O_FS = 9'd128,
                         O_RUN = 9'd256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] addr = REG;
  logic [15:0] wrData = '0;
  logic [3:0] besl = '0;
  logic hostConfigured = 1'b0, hostEnabled = 1'b0;
  logic resetDone = 1'b0, resumeDone = 1'b0, disconnect = 1'b0, dnResumeDone = 1'b0;
  logic [15:0] rdData;
  logic busResetReq, resumeReq, l1ResumeReq, sofEn, testJOut, testKOut;
  logic autoResumeEn, forceFullSpeed, hostRun;
  logic [8:0] outs;

  logic [3:0] beslL = '0;
  logic cfgL = 1'b0, enL = 1'b0;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  typedef struct {
    string tag;
    bit kind;
    logic [15:0] val;
  } item_t;
  item_t q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  host_sig_ctrl i_host_sig_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .besl(besl), .hostConfigured(hostConfigured),
    .hostEnabled(hostEnabled), .resetDone(resetDone), .resumeDone(resumeDone),
    .disconnect(disconnect), .dnResumeDone(dnResumeDone),
    .busResetReq(busResetReq), .resumeReq(resumeReq), .l1ResumeReq(l1ResumeReq),
    .sofEn(sofEn), .testJOut(testJOut), .testKOut(testKOut),
    .autoResumeEn(autoResumeEn), .forceFullSpeed(forceFullSpeed), .hostRun(hostRun)
  );

  assign outs = {hostRun, forceFullSpeed, autoResumeEn, testKOut, testJOut,
                 sofEn, l1ResumeReq, resumeReq, busResetReq};

  task automatic drv(input logic w, input logic [7:0] a, input logic [15:0] d,
                     input logic [3:0] ev);
    @(negedge clk);
    wrEn = w; addr = a; wrData = d;
    resetDone = ev[0]; resumeDone = ev[1]; disconnect = ev[2]; dnResumeDone = ev[3];
    besl = beslL; hostConfigured = cfgL; hostEnabled = enL;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drv(1'b0, REG, 16'h0000, 4'b0000);
  endtask

  task automatic expR(input string tag, input logic [15:0] v);
    item_t it;
    it.tag = tag; it.kind = 1'b0; it.val = v;
    q.push_back(it);
  endtask

  task automatic expO(input string tag, input logic [8:0] v);
    item_t it;
    it.tag = tag; it.kind = 1'b1; it.val = {7'd0, v};
    q.push_back(it);
  endtask

  // monitor: compares queued expectations two units after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (q.size() > 0) begin
        item_t it;
        logic [15:0] got;
        it = q.pop_front();
        got = it.kind ? {7'd0, outs} : rdData;
        checks++;
        if (got !== it.val) begin
          fails++;
          $display("FAIL %s %s actual=0x%04h expected=0x%04h", it.tag,
                   it.kind ? "outputs" : "rdData", got, it.val);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle(1);
    expR("R1", 16'h0000); expO("R1", 9'd0);

    // all ones: reset set in same write cancels resume, L1 refused (SOF was 0)
    drv(1'b1, REG, 16'hFFFF, 4'b0000);
    expR("R2", 16'h077C);
    expO("R11", O_RST | O_SOF | O_TJ | O_AR | O_FS);
    drv(1'b0, REG, 16'h0000, EV_RST);
    expO("R4", O_SOF | O_TJ | O_AR | O_FS);
    drv(1'b1, REG, 16'h0000, 4'b0000);
    expR("R2", 16'h0000); expO("R2", 9'd0);
    drv(1'b1, REG, 16'hF081, 4'b0000);
    expR("R2", 16'h0000);

    // host run gate
    cfgL = 1'b1; enL = 1'b1;
    drv(1'b1, REG, 16'h0400, 4'b0000);
    expO("R9", O_RUN);
    enL = 1'b0;
    idle(1);
    expO("R9", 9'd0);
    enL = 1'b1;
    drv(1'b1, REG, 16'h0000, 4'b0000);
    expO("R9", 9'd0);
    enL = 1'b0;

    // speed field
    drv(1'b1, REG, 16'h0004, 4'b0000); expO("R10", 9'd0);
    drv(1'b1, REG, 16'h0008, 4'b0000); expO("R10", 9'd0);
    drv(1'b1, REG, 16'h000C, 4'b0000); expO("R10", O_FS); expR("R10", 16'h000C);

    // test states
    drv(1'b1, REG, 16'h0040, 4'b0000); expO("R11", O_TK);
    drv(1'b1, REG, 16'h0060, 4'b0000); expO("R11", O_TJ); expR("R11", 16'h0060);

    // resume
    drv(1'b1, REG, 16'h0002, 4'b0000); expO("R3", O_RES); expR("R3", 16'h0002);
    drv(1'b1, REG, 16'h0000, 4'b0000); expO("R3", O_RES);
    drv(1'b0, REG, 16'h0000, EV_RES);  expO("R3", 9'd0);

    // bus reset
    drv(1'b1, REG, 16'h0200, 4'b0000); expO("R4", O_RST);
    drv(1'b1, REG, 16'h0000, 4'b0000); expO("R4", O_RST);
    drv(1'b0, REG, 16'h0000, EV_DISC); expO("R4", 9'd0);

    // reset cancels resume, then reset end sets SOF
    drv(1'b1, REG, 16'h0002, 4'b0000); expO("R5", O_RES);
    drv(1'b1, REG, 16'h0200, 4'b0000); expO("R5", O_RST);
    drv(1'b0, REG, 16'h0000, EV_RST);  expO("R6", O_SOF); expR("R6", 16'h0100);

    // L1 refused while SOF off
    drv(1'b1, REG, 16'h0000, 4'b0000);
    drv(1'b1, REG, 16'h0800, 4'b0000); expO("R7", 9'd0); expR("R7", 16'h0000);

    // L1 length with BESL=1: 128 cycles, BESL captured at the write
    drv(1'b1, REG, 16'h0100, 4'b0000);
    beslL = 4'd1;
    drv(1'b1, REG, 16'h0800, 4'b0000); expO("R8", O_L1); expR("R7", 16'h0800);
    beslL = 4'd0;
    idle(127); expO("R8", O_L1);
    idle(1);   expO("R8", O_SOF); expR("R8", 16'h0100);

    // L1 with BESL=0: 64 cycles
    drv(1'b1, REG, 16'h0900, 4'b0000); expO("R8", O_L1 | O_SOF);
    idle(63); expO("R8", O_L1 | O_SOF);
    idle(1);  expO("R8", O_SOF);

    // reset cancels L1
    drv(1'b1, REG, 16'h0900, 4'b0000); expO("R5", O_L1 | O_SOF);
    drv(1'b1, REG, 16'h0300, 4'b0000); expO("R5", O_RST | O_SOF);
    drv(1'b0, REG, 16'h0000, EV_RST);  expO("R4", O_SOF);

    // downstream resume end, and its priority over a write of 0
    drv(1'b1, REG, 16'h0000, 4'b0000); expO("R6", 9'd0);
    drv(1'b0, REG, 16'h0000, EV_DNR);  expO("R6", O_SOF);
    drv(1'b1, REG, 16'h0000, EV_DNR);  expO("R6", O_SOF);

    // completion beats a same-cycle request
    drv(1'b1, REG, 16'h0200, EV_RST); expO("R12", O_SOF); expR("R12", 16'h0100);
    drv(1'b1, REG, 16'h0102, EV_RES); expO("R12", O_SOF);

    // other address
    cfgL = 1'b1; enL = 1'b1;
    drv(1'b1, REG, 16'h0460, 4'b0000); expR("R2", 16'h0460); expO("R9", O_RUN | O_TJ);
    drv(1'b1, 8'h0C, 16'h0000, 4'b0000); expR("R2", 16'h0000);
    drv(1'b0, REG, 16'h0000, 4'b0000); expR("R2", 16'h0460);

    idle(2);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule